// File: doc/BRIEF.md
# Exchange-and-Add Execution Unit

This unit carries out one exchange-and-add step for a processor core. It takes a source register and a destination operand at a selected width of 8, 16 or 32 bits. The destination is either another register or a memory word. The unit writes the truncated sum of the two operands into the destination and then hands the old destination value back to the source register. In the same final cycle it publishes the arithmetic flags of the addition and reports the nominal cycle cost of the operation.

The register file sits outside the unit. The unit reads it through two combinational read ports and writes it through one write port with byte enables. A memory destination is reached through a read handshake and a write handshake. Each handshake has an acknowledge and a fault line, and a fault on either one aborts the operation. Decoding, address generation, protection checks and bus locking are handled elsewhere.

The sequence is fixed. The destination is written first, and the source register is written only after that write has completed cleanly. A faulted memory write therefore leaves every register and flag as it was.

Top module: `xadd_unit`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the cycle after `done`. A `start` raised while busy has no effect on the running operation and launches no second one.
- R2: The destination receives the sum of the source and old destination values, truncated to the selected width. For a register destination this is written on the second cycle to `dstIdx`. For a memory destination it goes out on `memWrData`, with the bits above the width at zero.
- R3: In the final cycle, and only after the destination write has completed without a fault, the source register receives the old destination value.
- R4: `flagsOut` carries the flags of the addition at the selected width: bit0 carry, bit1 parity (1 when the low result byte has an even number of ones), bit2 carry out of bit 3, bit3 zero, bit4 sign, bit5 signed overflow. They are valid while `flagWrEn` is high, which happens only in the final cycle of an operation that did not fault.
- R5: With a register destination, `done` rises in the 3rd cycle after the accepting edge. With a memory destination and same-cycle acknowledges, it rises in the 4th cycle. `cycleCost` reads 3 or 4 accordingly while `done` is high.
- R6: A fault reported with a read or write acknowledge raises `done` and `fault` in that same cycle. It produces no register write and no flag write. A read fault also produces no memory write.
- R7: `sizeSel` codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. The byte enables `regWrBe` and `memWrBe` are 0001, 0011 and 1111 respectively. Register bytes outside the width are preserved.
- R8: When the source and destination name the same register, that register ends holding its old value.
- R9: `memRdReq` and `memWrReq` stay high until acknowledged. The write request starts only after a read that was acknowledged without a fault. Each wait cycle adds one cycle before `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation |
| sizeSel | input | 2 | Operand width code |
| dstIsMem | input | 1 | Destination is a memory word |
| srcIdx | input | IDX_W | Source register index |
| dstIdx | input | IDX_W | Destination register index |
| busy | output | 1 | Operation in progress |
| rdIdxA | output | IDX_W | Register read port A index (source) |
| rdDataA | input | 32 | Register read port A data |
| rdIdxB | output | IDX_W | Register read port B index (destination) |
| rdDataB | input | 32 | Register read port B data |
| regWrEn | output | 1 | Register write strobe |
| regWrIdx | output | IDX_W | Register write index |
| regWrData | output | 32 | Register write data |
| regWrBe | output | 4 | Register write byte enables |
| memRdReq | output | 1 | Memory read request |
| memRdAck | input | 1 | Memory read acknowledge |
| memRdData | input | 32 | Memory read data |
| memRdFault | input | 1 | Read fault, valid with acknowledge |
| memWrReq | output | 1 | Memory write request |
| memWrData | output | 32 | Memory write data |
| memWrBe | output | 4 | Memory write byte enables |
| memWrAck | input | 1 | Memory write acknowledge |
| memWrFault | input | 1 | Write fault, valid with acknowledge |
| flagWrEn | output | 1 | Flags valid and to be committed |
| flagsOut | output | 6 | Updated flags |
| done | output | 1 | Operation complete strobe |
| fault | output | 1 | Operation aborted, with done |
| cycleCost | output | 3 | Nominal cycle cost, valid with done |

## Verification
The completion strobe and the abort path can fall in the same cycle. A handshake acknowledge that carries a fault must raise `done` and `fault` together while no register or flag write happens. The bench provokes this by injecting a fault on the read acknowledge, and separately on the write acknowledge, with and without wait cycles. It judges the result by the cycle in which `done` appears, the absence of any flag strobe, and the unchanged register and memory contents afterwards. Normal operations are swept arithmetically over many operand pairs at all three widths, including the case where source and destination are the same register.

// File: rtl/xadd_pkg.sv
package xadd_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int REG_COST = 3;
  localparam int MEM_COST = 4;

  typedef struct packed {
    logic latchOp;   // capture operation fields at start
    logic capRegs;   // capture both register operands
    logic capMem;    // capture destination from memory
    logic selSrcWb;  // write port targets the source register
  } dpStrobe_t;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } flags_t;

  function automatic logic [LANES-1:0] laneEnables(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int topBit(input logic [1:0] sz);
    case (sz)
      2'd0:    return 7;
      2'd1:    return 15;
      default: return 31;
    endcase
  endfunction
endpackage

// File: rtl/xadd_ctrl.sv
module xadd_ctrl
  import xadd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      opIsMem,
  input  logic      memRdAck,
  input  logic      memRdFault,
  input  logic      memWrAck,
  input  logic      memWrFault,
  output dpStrobe_t stb,
  output logic      busy,
  output logic      regWrEn,
  output logic      memRdReq,
  output logic      memWrReq,
  output logic      flagWrEn,
  output logic      done,
  output logic      fault
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WDST, ST_MRD, ST_MWR, ST_FIN
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    regWrEn   = 1'b0;
    memRdReq  = 1'b0;
    memWrReq  = 1'b0;
    flagWrEn  = 1'b0;
    done      = 1'b0;
    fault     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          stb.latchOp = 1'b1;
          nextState   = ST_READ;
        end
      end
      ST_READ: begin
        stb.capRegs = 1'b1;
        nextState   = opIsMem ? ST_MRD : ST_WDST;
      end
      ST_WDST: begin
        regWrEn   = 1'b1;
        nextState = ST_FIN;
      end
      ST_MRD: begin
        memRdReq = 1'b1;
        if (memRdAck) begin
          if (memRdFault) begin
            done      = 1'b1;
            fault     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            stb.capMem = 1'b1;
            nextState  = ST_MWR;
          end
        end
      end
      ST_MWR: begin
        memWrReq = 1'b1;
        if (memWrAck) begin
          if (memWrFault) begin
            done      = 1'b1;
            fault     = 1'b1;
            nextState = ST_IDLE;
          end else begin
            nextState = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        regWrEn      = 1'b1;
        stb.selSrcWb = 1'b1;
        flagWrEn     = 1'b1;
        done         = 1'b1;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/xadd_dpath.sv
module xadd_dpath
  import xadd_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [1:0]        sizeIn,
  input  logic              isMemIn,
  input  logic [IDX_W-1:0]  srcIdxIn,
  input  logic [IDX_W-1:0]  dstIdxIn,
  input  logic [DATA_W-1:0] rdDataA,
  input  logic [DATA_W-1:0] rdDataB,
  input  logic [DATA_W-1:0] memRdData,
  output logic              opIsMem,
  output logic [IDX_W-1:0]  opSrcIdx,
  output logic [IDX_W-1:0]  opDstIdx,
  output logic [LANES-1:0]  opBe,
  output logic [DATA_W-1:0] sumVal,
  output logic [DATA_W-1:0] oldDst,
  output flags_t            flags
);
  logic [1:0]        opSize;
  logic [DATA_W-1:0] srcVal, dstVal, widthMask, opA, opB;
  logic [DATA_W:0]   wide;
  int                msb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opSize   <= '0;
      opIsMem  <= 1'b0;
      opSrcIdx <= '0;
      opDstIdx <= '0;
      srcVal   <= '0;
      dstVal   <= '0;
    end else begin
      if (stb.latchOp) begin
        opSize   <= sizeIn;
        opIsMem  <= isMemIn;
        opSrcIdx <= srcIdxIn;
        opDstIdx <= dstIdxIn;
      end
      if (stb.capRegs) begin
        srcVal <= rdDataA;
        dstVal <= rdDataB;
      end
      if (stb.capMem) dstVal <= memRdData;
    end
  end

  assign opBe = laneEnables(opSize);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign widthMask[8*g +: 8] = {8{opBe[g]}};
  end

  assign opA  = srcVal & widthMask;
  assign opB  = dstVal & widthMask;
  assign wide = {1'b0, opA} + {1'b0, opB};
  assign msb  = topBit(opSize);

  assign sumVal = wide[DATA_W-1:0] & widthMask;
  assign oldDst = opB;

  always_comb begin
    flags.cry = wide[msb+1];
    flags.sgn = wide[msb];
    flags.zro = (sumVal == '0);
    flags.aux = opA[4] ^ opB[4] ^ wide[4];
    flags.par = ~^wide[7:0];
    flags.ovf = (opA[msb] == opB[msb]) && (wide[msb] != opA[msb]);
  end
endmodule

// File: rtl/xadd_unit.sv
module xadd_unit
  import xadd_pkg::*;
#(
  parameter  int NUM_REGS = 8,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sizeSel,
  input  logic              dstIsMem,
  input  logic [IDX_W-1:0]  srcIdx,
  input  logic [IDX_W-1:0]  dstIdx,
  output logic              busy,
  output logic [IDX_W-1:0]  rdIdxA,
  input  logic [31:0]       rdDataA,
  output logic [IDX_W-1:0]  rdIdxB,
  input  logic [31:0]       rdDataB,
  output logic              regWrEn,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [31:0]       regWrData,
  output logic [3:0]        regWrBe,
  output logic              memRdReq,
  input  logic              memRdAck,
  input  logic [31:0]       memRdData,
  input  logic              memRdFault,
  output logic              memWrReq,
  output logic [31:0]       memWrData,
  output logic [3:0]        memWrBe,
  input  logic              memWrAck,
  input  logic              memWrFault,
  output logic              flagWrEn,
  output logic [5:0]        flagsOut,
  output logic              done,
  output logic              fault,
  output logic [2:0]        cycleCost
);
  dpStrobe_t         stb;
  flags_t            flags;
  logic              opIsMem;
  logic [IDX_W-1:0]  opSrcIdx, opDstIdx;
  logic [LANES-1:0]  opBe;
  logic [DATA_W-1:0] sumVal, oldDst;

  xadd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opIsMem(opIsMem),
    .memRdAck(memRdAck), .memRdFault(memRdFault),
    .memWrAck(memWrAck), .memWrFault(memWrFault),
    .stb(stb), .busy(busy), .regWrEn(regWrEn),
    .memRdReq(memRdReq), .memWrReq(memWrReq),
    .flagWrEn(flagWrEn), .done(done), .fault(fault)
  );

  xadd_dpath #(.IDX_W(IDX_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sizeIn(sizeSel), .isMemIn(dstIsMem),
    .srcIdxIn(srcIdx), .dstIdxIn(dstIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .memRdData(memRdData),
    .opIsMem(opIsMem), .opSrcIdx(opSrcIdx), .opDstIdx(opDstIdx),
    .opBe(opBe), .sumVal(sumVal), .oldDst(oldDst), .flags(flags)
  );

  assign rdIdxA    = opSrcIdx;
  assign rdIdxB    = opDstIdx;
  assign regWrIdx  = stb.selSrcWb ? opSrcIdx : opDstIdx;
  assign regWrData = stb.selSrcWb ? oldDst : sumVal;
  assign regWrBe   = opBe;
  assign memWrData = sumVal;
  assign memWrBe   = opBe;
  assign flagsOut  = flags;
  assign cycleCost = opIsMem ? 3'(MEM_COST) : 3'(REG_COST);
endmodule

// File: rtl/xadd_chk.sv
module xadd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       regWrEn,
  input logic [3:0] regWrBe,
  input logic       memRdReq,
  input logic       memRdAck,
  input logic       memRdFault,
  input logic       memWrReq,
  input logic       memWrAck,
  input logic       memWrFault,
  input logic       flagWrEn,
  input logic       done,
  input logic       fault
);
  assert_start_takes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_ends_R1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_src_after_dst_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fault && regWrEn) |->
      $past(regWrEn || (memWrReq && memWrAck && !memWrFault)));

  assert_flags_final_R4: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |-> (done && !fault && regWrEn));

  assert_fault_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (done && !regWrEn && !flagWrEn));

  assert_rdfault_nowrite_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck && memRdFault) |=> (!memWrReq && !busy));

  assert_be_shape_R7: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrBe == 4'b0001 || regWrBe == 4'b0011 || regWrBe == 4'b1111));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> memRdReq);

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !memWrAck) |=> memWrReq);

  assert_wr_after_rd_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrReq) |-> $past(memRdReq && memRdAck && !memRdFault));
endmodule

bind xadd_unit xadd_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy),
  .regWrEn(regWrEn), .regWrBe(regWrBe),
  .memRdReq(memRdReq), .memRdAck(memRdAck), .memRdFault(memRdFault),
  .memWrReq(memWrReq), .memWrAck(memWrAck), .memWrFault(memWrFault),
  .flagWrEn(flagWrEn), .done(done), .fault(fault)
);

// File: tb/sim_xadd_unit.sv
`timescale 1ns/1ps
module sim_xadd_unit;
  localparam int NREG  = 8;
  localparam int IW    = $clog2(NREG);
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [1:0]    sizeSel = '0;
  logic          dstIsMem = 1'b0;
  logic [IW-1:0] srcIdx = '0, dstIdx = '0;
  logic          busy;
  logic [IW-1:0] rdIdxA, rdIdxB, regWrIdx;
  logic [31:0]   rdDataA, rdDataB, regWrData, memWrData;
  logic          regWrEn, memRdReq, memWrReq, flagWrEn, done, fault;
  logic [3:0]    regWrBe, memWrBe;
  logic          memRdAck = 1'b0, memRdFault = 1'b0;
  logic          memWrAck = 1'b0, memWrFault = 1'b0;
  logic [5:0]    flagsOut;
  logic [2:0]    cycleCost;

  logic [31:0] rf [NREG];
  logic [31:0] memWord;
  logic        ldRegEn = 1'b0, ldMemEn = 1'b0;
  logic [IW-1:0] ldIdx = '0;
  logic [31:0] ldVal = '0;

  int memLat = 0;
  bit injRd = 0, injWr = 0;
  int rdWait = 0, wrWait = 0;
  int checks = 0, fails = 0, cycTotal = 0;

  xadd_unit #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sizeSel(sizeSel),
    .dstIsMem(dstIsMem), .srcIdx(srcIdx), .dstIdx(dstIdx), .busy(busy),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData), .regWrBe(regWrBe),
    .memRdReq(memRdReq), .memRdAck(memRdAck), .memRdData(memWord), .memRdFault(memRdFault),
    .memWrReq(memWrReq), .memWrData(memWrData), .memWrBe(memWrBe),
    .memWrAck(memWrAck), .memWrFault(memWrFault),
    .flagWrEn(flagWrEn), .flagsOut(flagsOut), .done(done), .fault(fault),
    .cycleCost(cycleCost)
  );

  assign rdDataA = rf[rdIdxA];
  assign rdDataB = rf[rdIdxB];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // Register file and memory models
  always @(posedge clk) begin
    if (ldRegEn) rf[ldIdx] <= ldVal;
    else if (regWrEn) rf[regWrIdx] <= merge(rf[regWrIdx], regWrData, regWrBe);
    if (ldMemEn) memWord <= ldVal;
    else if (memWrReq && memWrAck && !memWrFault) memWord <= merge(memWord, memWrData, memWrBe);
  end

  // Memory responder: acts shortly after each rising edge
  always begin
    @(posedge clk);
    #1;
    if (memRdReq) begin
      memRdAck   = (rdWait >= memLat);
      memRdFault = injRd && memRdAck;
      rdWait++;
    end else begin
      memRdAck = 1'b0; memRdFault = 1'b0; rdWait = 0;
    end
    if (memWrReq) begin
      memWrAck   = (wrWait >= memLat);
      memWrFault = injWr && memWrAck;
      wrWait++;
    end else begin
      memWrAck = 1'b0; memWrFault = 1'b0; wrWait = 0;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycTotal++;
    if (cycTotal > LIMIT) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under %0d", cycTotal, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] widthMask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] expBe(input logic [1:0] sz);
    return (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  // {ovf,sgn,zro,aux,par,cry}
  function automatic logic [5:0] expFlags(input logic [1:0] sz, input logic [31:0] a,
                                          input logic [31:0] b);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    longint full = longint'(1) << w;
    longint half = longint'(1) << (w - 1);
    longint ua = longint'(a), ub = longint'(b);
    longint s = ua + ub;
    longint res = s % full;
    longint sa = (ua >= half) ? ua - full : ua;
    longint sb = (ub >= half) ? ub - full : ub;
    longint ss = sa + sb;
    logic c, p, h, z, n, o;
    c = (s >= full);
    p = ($countones(res[7:0]) % 2) == 0;
    h = ((ua % 16) + (ub % 16)) > 15;
    z = (res == 0);
    n = (res >= half);
    o = (ss >= half) || (ss < -half);
    return {o, n, z, h, p, c};
  endfunction

  task automatic loadReg(input int idx, input logic [31:0] v);
    ldRegEn = 1'b1; ldIdx = IW'(idx); ldVal = v;
    @(negedge clk);
    ldRegEn = 1'b0;
  endtask

  task automatic loadMem(input logic [31:0] v);
    ldMemEn = 1'b1; ldVal = v;
    @(negedge clk);
    ldMemEn = 1'b0;
  endtask

  // Runs one operation from a falling edge; checks results afterwards.
  task automatic runOp(input logic [1:0] sz, input bit isMem, input int s, input int d,
                       input int lat, input bit rdF, input bit wrF, input bit poke);
    logic [31:0] m, preSrc, preDst, a, b, expSum, gotDst;
    logic [5:0]  gotFlags;
    logic [2:0]  gotCost;
    bit          flagSeen, wrSeen, gotFault, extraWr;
    int          cyc, expCyc, wInt;
    m = widthMask(sz);
    preSrc = rf[s];
    preDst = isMem ? memWord : rf[d];
    a = preSrc & m;
    b = preDst & m;
    expSum = (a + b) & m;
    memLat = lat; injRd = rdF; injWr = wrF;
    sizeSel = sz; dstIsMem = isMem; srcIdx = IW'(s); dstIdx = IW'(d);
    start = 1'b1;
    cyc = 0; flagSeen = 0; wrSeen = 0; gotFlags = '0;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        start = poke;
        check(busy == 1'b1, "R1 busy after accept", 32'(busy), 1);
        if (poke) begin
          // different operands while busy must be ignored
          srcIdx = IW'(d); dstIdx = IW'(s); sizeSel = 2'd2;
        end
      end
      if (cyc == 2) start = 1'b0;
      if (flagWrEn) begin flagSeen = 1; gotFlags = flagsOut; end
      if (memWrReq) wrSeen = 1;
      if (regWrEn && cyc < 3 && !isMem)
        check(regWrBe == expBe(sz), "R7 byte enables", 32'(regWrBe), 32'(expBe(sz)));
      if (memWrReq)
        check(memWrBe == expBe(sz) && memWrData == expSum, "R2 memory write data",
              memWrData, expSum);
    end while (!done && cyc < 60);
    gotFault = fault; gotCost = cycleCost;
    start = 1'b0;
    @(negedge clk);
    extraWr = regWrEn;
    check(!busy && !extraWr, "R1 idle after done", 32'(busy), 0);

    wInt = (lat > 0) ? lat : 0;
    if (!isMem) expCyc = 3;
    else if (rdF) expCyc = 2 + wInt;
    else if (wrF) expCyc = 3 + 2 * wInt;
    else expCyc = 4 + 2 * wInt;
    check(cyc == expCyc, isMem ? "R9 cycles to done" : "R5 cycles to done",
          32'(cyc), 32'(expCyc));

    if (rdF || wrF) begin
      check(gotFault && !flagSeen, "R6 fault strobe and no flags", 32'(gotFault), 1);
      check(rf[s] == preSrc, "R6 source register untouched", rf[s], preSrc);
      check(memWord == preDst, "R6 memory untouched", memWord, preDst);
      if (rdF) check(!wrSeen, "R6 no write after read fault", 32'(wrSeen), 0);
    end else begin
      check(!gotFault, "R6 no spurious fault", 32'(gotFault), 0);
      check(gotCost == (isMem ? 3'd4 : 3'd3), "R5 cycle cost", 32'(gotCost),
            isMem ? 32'd4 : 32'd3);
      if (s != d || isMem) begin
        gotDst = isMem ? memWord : rf[d];
        check(gotDst == ((preDst & ~m) | expSum), "R2 destination sum", gotDst,
              (preDst & ~m) | expSum);
        check(rf[s] == ((preSrc & ~m) | b), "R3 R7 source gets old destination", rf[s],
              (preSrc & ~m) | b);
      end else begin
        check(rf[s] == preDst, "R8 same register keeps old value", rf[s], preDst);
      end
      check(flagSeen && gotFlags == expFlags(sz, a, b), "R4 flags", 32'(gotFlags),
            32'(expFlags(sz, a, b)));
    end
  endtask

  logic [31:0] corner16 [8];
  logic [31:0] corner32 [8];

  initial begin
    corner16 = '{32'h0, 32'h1, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h00FF, 32'h0F0F, 32'h1234};
    corner32 = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF,
                 32'h0000_FFFF, 32'h0F0F_0F0F, 32'h89AB_CDEF};
    for (int i = 0; i < NREG; i++) rf[i] = 32'h1111_1111 * i;
    memWord = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !regWrEn && !memRdReq && !memWrReq && !flagWrEn,
          "R1 reset outputs quiet", {busy, done, regWrEn, memRdReq, memWrReq, flagWrEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // 8-bit register sweep, upper bytes must survive (R7)
    for (int x = 0; x < 256; x += 5)
      for (int y = 0; y < 256; y += 7) begin
        loadReg(1, {24'hC35A96, 8'(x)});
        loadReg(2, {24'h7EE718, 8'(y)});
        runOp(2'd0, 0, 1, 2, 0, 0, 0, 0);
      end
    // 16-bit register corners, swapped register roles
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        loadReg(5, 32'hABCD_0000 | corner16[x]);
        loadReg(3, 32'h5432_0000 | corner16[y]);
        runOp(2'd1, 0, 5, 3, 0, 0, 0, 0);
      end
    // 32-bit register and memory corners, memory with and without waits (R9)
    for (int x = 0; x < 8; x++)
      for (int y = 0; y < 8; y++) begin
        loadReg(0, corner32[x]);
        loadReg(7, corner32[y]);
        runOp(2'd2, 0, 0, 7, 0, 0, 0, 0);
        loadReg(4, corner32[x]);
        loadMem(corner32[y]);
        runOp(2'(2 + (x % 2)), 1, 4, 0, (x + y) % 3, 0, 0, 0);
      end
    // 8-bit memory sweep
    for (int x = 0; x < 256; x += 17)
      for (int y = 0; y < 256; y += 19) begin
        loadReg(6, {24'h0102_03, 8'(x)});
        loadMem({24'hF0E0_D0, 8'(y)});
        runOp(2'd0, 1, 6, 0, 0, 0, 0, 0);
      end
    // R8 same register at each width
    for (int z = 0; z < 3; z++) begin
      loadReg(3, 32'h8765_43A9 + z);
      runOp(2'(z), 0, 3, 3, 0, 0, 0, 0);
    end
    // R6 faults on read and on write, with and without waits
    for (int lat = 0; lat < 3; lat++) begin
      loadReg(2, 32'h1357_9BDF);
      loadMem(32'h2468_ACE0);
      runOp(2'd2, 1, 2, 0, lat, 1, 0, 0);
      runOp(2'd1, 1, 2, 0, lat, 0, 1, 0);
      runOp(2'd0, 1, 2, 0, lat, 0, 0, 0);
    end
    // R1 start raised while busy is ignored
    loadReg(1, 32'h0000_00F0);
    loadReg(6, 32'h0000_0020);
    runOp(2'd0, 0, 1, 6, 0, 0, 0, 1);
    loadReg(4, 32'h4000_0000);
    loadMem(32'h4000_0000);
    runOp(2'd2, 1, 4, 0, 1, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule